// File: doc/BRIEF.md
# CPU Clock Divider Tree

This block produces the CPU clock level from two slow source waveforms, a crystal reference and a PLL output, both sampled on a fast fabric clock. A first selector chooses which source feeds a programmable divider. A second selector chooses whether the CPU clock comes from that divider or straight from the crystal, so the crystal can stand in while the PLL is retuned. The divider counts rising edges of the selected source and divides by 1, 2, 3 or twice a 9-bit factor.

Two control words sit behind a simple write port with a combinational read port. The source selector, the output selector and a 2-bit ratio code live in one word. The 9-bit factor lives in the other. A status output reports the divide ratio that the current register contents ask for. A ratio change never cuts a period short: the divider picks up the new value only when its current output period ends.

Top module: `cpu_clk_tree`

## Requirements
- R1: After a synchronous active-low reset both control words read zero, `ratio_o` is 1, and `cpu_clk` is low and follows the crystal.
- R2: A write with `wr_en` high updates the word at `addr` on that clock edge. Offset 0x00 holds the factor N in bits [28:20]. Offset 0x40 holds the source selector in bit 0, the ratio code in bits [3:2] and the output selector in bit 7. All other bits read as zero, and any other offset reads zero and ignores writes.
- R3: With source selector 1 the divider counts PLL rising edges. With source selector 0 it counts crystal rising edges.
- R4: With output selector 0, `cpu_clk` equals the crystal level sampled on the previous fabric clock edge, whatever the PLL and divider do.
- R5: `ratio_o` equals code+1 for codes 0, 1 and 2, and 2×N for code 3. It is valid one cycle after the write.
- R6: With output selector 1, ratio 1 passes the sampled source level through. Ratio 3 gives one source period high and two low. An even ratio 2N gives N source periods high and N low. Each output period starts high on a source rising edge.
- R7: With code 3 and N = 0, the divider output stays low and does not toggle.
- R8: A new code or N value takes effect at the first source rising edge that ends the current output period. An idle divider takes it at the next source rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples the sources and runs all state |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_in | input | 1 | Crystal reference waveform |
| pll_in | input | 1 | PLL output waveform |
| wr_en | input | 1 | Write strobe for the control words |
| addr | input | 8 | Control word offset for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| cpu_clk | output | 1 | Derived CPU clock level |
| ratio_o | output | 10 | Divide ratio requested by the registers |

## Verification
Every result except the read port lands one fabric clock after its cause. A write shows on `rdata` and `ratio_o` after the edge that takes it. A source rising edge sampled on an edge moves `cpu_clk` right after that same edge, so the crystal bypass lags the crystal pin by one cycle. The bench keeps a behavioural model that advances on the same rising edge as the design, and it compares `cpu_clk` and `ratio_o` at every falling edge, half a cycle after the edge that made them. Register reads are checked shortly after the falling edge that drives the address.

// File: rtl/cct_pkg.sv
// Package: field positions of the two control words of the CPU clock tree.
// Assumes the N field and every flag lie inside a 32-bit data word.
package cct_pkg;
    localparam int SRC_BIT = 0;   // divider source: 1 = PLL, 0 = crystal
    localparam int SEL_LSB = 2;   // 2-bit ratio code
    localparam int OUT_BIT = 7;   // output: 1 = divider, 0 = crystal
    localparam int N_LSB   = 20;  // factor N in the factor word
endpackage

// File: rtl/cct_regs.sv
// Module: control word storage with a write port and a combinational read port.
// Assumes a single writer. Undefined bits and offsets read zero.
module cct_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int N_W    = 9,
    parameter logic [ADDR_W-1:0] OFF_N   = 'h00,
    parameter logic [ADDR_W-1:0] OFF_CTL = 'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              src_sel,
    output logic              out_sel,
    output logic [1:0]        div_sel,
    output logic [N_W-1:0]    n_val
);
    import cct_pkg::*;

    // Purpose: store the fields on a matching write, clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel <= 1'b0;
            out_sel <= 1'b0;
            div_sel <= 2'd0;
            n_val   <= '0;
        end else if (wr_en) begin
            if (addr == OFF_N) begin
                n_val <= wdata[N_LSB +: N_W];
            end else if (addr == OFF_CTL) begin
                src_sel <= wdata[SRC_BIT];
                out_sel <= wdata[OUT_BIT];
                div_sel <= wdata[SEL_LSB +: 2];
            end
        end
    end

    // Purpose: place the stored fields back at their bit positions for reads.
    always_comb begin
        rdata = '0;
        if (addr == OFF_N) begin
            rdata[N_LSB +: N_W] = n_val;
        end else if (addr == OFF_CTL) begin
            rdata[SRC_BIT]      = src_sel;
            rdata[OUT_BIT]      = out_sel;
            rdata[SEL_LSB +: 2] = div_sel;
        end
    end
endmodule

// File: rtl/cct_src_sel.sv
// Module: samples both source waveforms and picks the one feeding the divider.
// Assumes each source stays at a level for at least one fabric clock.
module cct_src_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_in,
    input  logic pll_in,
    input  logic src_sel,
    output logic xtal_q,
    output logic src_q,
    output logic src_rise
);
    logic pll_q;

    // Purpose: hold the previous sampled level of each source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xtal_q <= 1'b0;
            pll_q  <= 1'b0;
        end else begin
            xtal_q <= xtal_in;
            pll_q  <= pll_in;
        end
    end

    // Purpose: select the source level and flag its rising edge.
    always_comb begin
        src_q    = src_sel ? pll_q : xtal_q;
        src_rise = src_sel ? (pll_in & ~pll_q) : (xtal_in & ~xtal_q);
    end
endmodule

// File: rtl/cct_divider.sv
// Module: divides a stream of source rising edges by a ratio taken at period ends.
// Assumes ratio 0 means idle. Ratio 1 passes the sampled source level through.
module cct_divider #(
    parameter int RW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_rise,
    input  logic          src_q,
    input  logic [RW-1:0] req_ratio,
    output logic [RW-1:0] act_ratio,
    output logic          div_out
);
    logic [RW-1:0] cnt;
    logic [RW-1:0] cnt_nx;
    logic [RW-1:0] high_len;
    logic          period_end;
    logic          lvl;

    // Purpose: work out the period end and the high-phase length of the active ratio.
    always_comb begin
        cnt_nx     = cnt + RW'(1);
        high_len   = (act_ratio == RW'(3)) ? RW'(1) : (act_ratio >> 1);
        period_end = (act_ratio == '0) || (cnt_nx == act_ratio);
    end

    // Purpose: count source edges, load a new ratio at each period end, set the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            act_ratio <= '0;
            lvl       <= 1'b0;
        end else if (src_rise) begin
            if (period_end) begin
                cnt       <= '0;
                act_ratio <= req_ratio;
                lvl       <= (req_ratio != '0);
            end else begin
                cnt <= cnt_nx;
                lvl <= (cnt_nx < high_len);
            end
        end
    end

    // Purpose: with ratio 1 follow the source itself, otherwise the counted level.
    always_comb begin
        div_out = (act_ratio == RW'(1)) ? src_q : lvl;
    end
endmodule

// File: rtl/cpu_clk_tree.sv
// Module: top of the CPU clock tree: registers, source selector, divider, output selector.
// Assumes both sources are much slower than clk, and that cpu_clk is a level
// sampled in the clk domain, not a clock network.
module cpu_clk_tree #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int N_W    = 9,
    parameter logic [ADDR_W-1:0] OFF_N   = 'h00,
    parameter logic [ADDR_W-1:0] OFF_CTL = 'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xtal_in,
    input  logic              pll_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              cpu_clk,
    output logic [N_W:0]      ratio_o
);
    localparam int RW = N_W + 1;

    logic           src_sel;
    logic           out_sel;
    logic [1:0]     div_sel;
    logic [N_W-1:0] n_val;
    logic           xtal_q;
    logic           src_q;
    logic           src_rise;
    logic [RW-1:0]  req_ratio;
    logic [RW-1:0]  act_ratio;
    logic           div_out;

    cct_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_W(N_W),
        .OFF_N(OFF_N), .OFF_CTL(OFF_CTL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src_sel(src_sel), .out_sel(out_sel),
        .div_sel(div_sel), .n_val(n_val)
    );

    cct_src_sel u_src (
        .clk(clk), .rst_n(rst_n), .xtal_in(xtal_in), .pll_in(pll_in),
        .src_sel(src_sel), .xtal_q(xtal_q), .src_q(src_q), .src_rise(src_rise)
    );

    // Purpose: turn the ratio code and the factor into the requested ratio.
    always_comb begin
        req_ratio = (div_sel == 2'd3) ? {n_val, 1'b0} : (RW'(div_sel) + RW'(1));
    end

    cct_divider #(.RW(RW)) u_div (
        .clk(clk), .rst_n(rst_n), .src_rise(src_rise), .src_q(src_q),
        .req_ratio(req_ratio), .act_ratio(act_ratio), .div_out(div_out)
    );

    // Purpose: final selector between the divider and the crystal bypass.
    always_comb begin
        cpu_clk = out_sel ? div_out : xtal_q;
        ratio_o = req_ratio;
    end
endmodule

// File: rtl/cpu_clk_tree_chk.sv
// Module: assertion checker for the CPU clock tree, bound to every instance of the top.
module cpu_clk_tree_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int N_W    = 9,
    parameter logic [ADDR_W-1:0] OFF_N   = 'h00,
    parameter logic [ADDR_W-1:0] OFF_CTL = 'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xtal_in,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              cpu_clk,
    input logic [N_W:0]      ratio_o,
    input logic              out_sel,
    input logic              src_rise,
    input logic [N_W:0]      act_ratio
);
    import cct_pkg::*;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ratio_o == (N_W+1)'(1)) && !cpu_clk);

    a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != OFF_N && addr != OFF_CTL) |-> (rdata == '0));

    a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !out_sel) |-> (cpu_clk == $past(xtal_in)));

    a_r5_small_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFF_CTL && rdata[SEL_LSB +: 2] != 2'd3)
            |-> (ratio_o == (N_W+1)'(rdata[SEL_LSB +: 2]) + (N_W+1)'(1)));

    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel && act_ratio == '0) |-> !cpu_clk);

    a_r8_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        !src_rise |=> $stable(act_ratio));
endmodule

bind cpu_clk_tree cpu_clk_tree_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_W(N_W), .OFF_N(OFF_N), .OFF_CTL(OFF_CTL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .xtal_in(xtal_in), .addr(addr), .rdata(rdata),
    .cpu_clk(cpu_clk), .ratio_o(ratio_o), .out_sel(out_sel),
    .src_rise(src_rise), .act_ratio(act_ratio)
);

// File: tb/cpu_clk_tree_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural cycle model of the clock tree, compared at every falling edge.
module cpu_clk_tree_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_in = 1'b0;
    logic        pll_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        cpu_clk;
    logic [9:0]  ratio_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state
    int m_n = 0, m_sel = 0, m_src = 0, m_out = 0;
    int m_act = 0, m_cnt = 0, m_lvl = 0, m_xq = 0, m_pq = 0;
    int xdiv = 0, pdiv = 0;

    cpu_clk_tree dut_i (
        .clk(clk), .rst_n(rst_n), .xtal_in(xtal_in), .pll_in(pll_in),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .cpu_clk(cpu_clk), .ratio_o(ratio_o)
    );

    always #10 clk = ~clk;

    function automatic int want_ratio(int sel, int n);
        return (sel == 3) ? 2 * n : sel + 1;
    endfunction

    function automatic int high_len(int r);
        return (r == 3) ? 1 : r / 2;
    endfunction

    function automatic int want_clk();
        if (m_out == 0) return m_xq;
        if (m_act == 1) return (m_src != 0) ? m_pq : m_xq;
        return m_lvl;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Model: advance on the same edge as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_n = 0; m_sel = 0; m_src = 0; m_out = 0;
            m_act = 0; m_cnt = 0; m_lvl = 0; m_xq = 0; m_pq = 0;
        end else begin
            int s_in, s_q;
            s_in = (m_src != 0) ? int'(pll_in) : int'(xtal_in);
            s_q  = (m_src != 0) ? m_pq : m_xq;
            if (s_in == 1 && s_q == 0) begin
                if (m_act == 0 || m_cnt == m_act - 1) begin
                    m_act = want_ratio(m_sel, m_n);
                    m_cnt = 0;
                    m_lvl = (m_act != 0);
                end else begin
                    m_cnt++;
                    m_lvl = (m_cnt < high_len(m_act));
                end
            end
            if (wr_en) begin
                if (addr == 8'h00) m_n = int'(wdata[28:20]);
                else if (addr == 8'h40) begin
                    m_src = wdata[0]; m_sel = int'(wdata[3:2]); m_out = wdata[7];
                end
            end
            m_xq = xtal_in;
            m_pq = pll_in;
        end
    end

    // Compare outputs, then move the source waveforms (crystal period 6, PLL period 4).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string tag;
            if (m_out == 0) tag = "R4";
            else if (m_act == 0) tag = "R7";
            else if (m_act != want_ratio(m_sel, m_n)) tag = "R8";
            else if (m_src != 0) tag = "R3";
            else tag = "R6";
            check(tag, int'(cpu_clk), want_clk());
            check("R5", int'(ratio_o), want_ratio(m_sel, m_n));
        end
        xdiv++; pdiv++;
        if (xdiv == 3) begin xdiv = 0; xtal_in = ~xtal_in; end
        if (pdiv == 2) begin pdiv = 0; pll_in = ~pll_in; end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00; wdata = '0;
    endtask

    task automatic wr_ctl(int src, int sel, int out);
        wr(8'h40, (32'(out) << 7) | (32'(sel) << 2) | 32'(src));
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #2;
        check(tag, int'(rdata), int'(exp));
        addr = 8'h00;
    endtask

    task automatic run(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #2;
        check("R1", int'(ratio_o), 1);
        check("R1", int'(cpu_clk), 0);
        rd_chk("R1", 8'h00, 32'h0);
        rd_chk("R1", 8'h40, 32'h0);
        run(20);

        // R2: field positions, masking and unmapped offsets
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        rd_chk("R2", 8'h00, 32'h1FF0_0000);
        rd_chk("R2", 8'h40, 32'h0000_008D);
        check("R5", int'(ratio_o), 1022);
        wr(8'h20, 32'hFFFF_FFFF);
        rd_chk("R2", 8'h20, 32'h0);
        wr(8'h44, 32'h0);
        rd_chk("R2", 8'h40, 32'h0000_008D);
        wr(8'h00, 32'h0);
        wr_ctl(0, 0, 0);
        run(20);

        // R6 / R3: small ratios from the crystal, then from the PLL
        for (int src = 0; src < 2; src++) begin
            for (int sel = 0; sel < 3; sel++) begin
                wr_ctl(src, sel, 1);
                run(60);
            end
        end

        // R6: even ratios 2N
        wr(8'h00, 32'(2) << 20);
        wr_ctl(0, 3, 1);
        check("R5", int'(ratio_o), 4);
        run(80);
        wr(8'h00, 32'(3) << 20);
        run(100);

        // R8: shrink N mid-period, then grow it
        wr(8'h00, 32'(1) << 20);
        run(60);
        wr_ctl(1, 3, 1);
        wr(8'h00, 32'(5) << 20);
        run(100);

        // R7: N = 0 holds the divider idle and low
        wr(8'h00, 32'h0);
        check("R5", int'(ratio_o), 0);
        run(120);
        wr_ctl(0, 2, 1);
        run(60);

        // R4: retune sequence: crystal bypass, PLL as source, back to divider
        wr_ctl(0, 1, 0);
        run(40);
        wr_ctl(1, 1, 0);
        run(40);
        wr_ctl(1, 1, 1);
        run(60);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule